// File: doc/BRIEF.md
# Prescaled Seconds Real-Time Counter

This block keeps wall-clock time from a periodic tick strobe. A six-bit prescaler counts incoming ticks, and on every sixty-fourth tick it returns to zero and advances a 32-bit seconds count by one. Every tick also raises a one-cycle interrupt pulse, so software can run periodic work without polling the count.

Software reaches the block over a small 16-bit register bus with three registers: a status word, a low seconds half and a high seconds half. The prescaler shows in the bottom six bits of the status word. The ten bits above it are general flags that software writes and the tick never changes. Reading the low half also copies the current upper half into a shadow register, and the high-half register returns that shadow. A low-then-high read pair therefore gives one consistent 32-bit value, even when a carry falls between the two reads. To set the time, software writes the low half to a staging register and then writes the high half. The second write commits both halves on the next clock and clears the prescaler.

Top module: `rt_seconds`

## Requirements
- R1: After reset the prescaler, seconds count, flags, staging and shadow registers are all zero, `tick_irq` is low and `rdata` is zero.
- R2: A tick with the prescaler below 63 adds one to the prescaler (status bits 5:0) and leaves the seconds count unchanged.
- R3: A tick with the prescaler at 63 sets the prescaler to 0 and adds one to the seconds count. A carry out of bit 15 propagates into the upper half.
- R4: A write to address 0 stores `wdata[15:6]` into status bits 15:6. It does not change the prescaler, and ticks never change those flag bits.
- R5: A read is registered, so `rdata` shows the selected register in the cycle after `rd_en`. Address 0 returns {flags, prescaler}, address 1 returns seconds bits 15:0, and address 2 returns the shadow. `rdata` holds its value while `rd_en` is low.
- R6: A read of address 1 loads seconds bits 31:16 into the shadow. The value is taken before any tick in the same cycle is applied. A later read of address 2 returns that captured value, even if the count has carried in between.
- R7: `tick_irq` is high for exactly the one cycle after each cycle in which `tick` is high, and low otherwise.
- R8: A write to address 1 stores `wdata` into a staging register. A write to address 2 sets the seconds count to {wdata, staging} and clears the prescaler on the next clock. This load wins over a tick in the same cycle.
- R9: The seconds count wraps from 0xFFFFFFFF to 0 on a carry.
- R10: A read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Periodic tick strobe, one cycle per tick |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 status, 1 low half, 2 high half |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| tick_irq | output | 1 | One-cycle pulse following each tick |

## Verification
The hardest case to reach from the ports is a low-half read in the same cycle as the tick that carries into the upper half. This is the case that the shadow register exists to handle. The stimulus first loads 0x0000FFFF through the staging path. It then issues 63 ticks to bring the prescaler to its top value, and finally pairs the next tick with a low-half read. A second load of 0xFFFFFFFF, followed by a full prescaler period, drives the wrap to zero. A behavioural model runs alongside and is compared against `rdata` and `tick_irq` on every clock.

// File: rtl/rt_seconds.sv
module rt_seconds #(
  parameter int DIV_W = 6,
  parameter int BUS_W = 16,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             tick_irq
);
  localparam int SEC_W  = 2 * BUS_W;
  localparam int FLAG_W = BUS_W - DIV_W;
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_LO   = AW'(1);
  localparam logic [AW-1:0] A_HI   = AW'(2);

  logic [DIV_W-1:0]  div_q;
  logic [SEC_W-1:0]  sec_q;
  logic [FLAG_W-1:0] flag_q;
  logic [BUS_W-1:0]  stage_q;
  logic [BUS_W-1:0]  shadow_q;

  wire wr_stat  = wr_en && (addr == A_STAT);
  wire wr_stage = wr_en && (addr == A_LO);
  wire load     = wr_en && (addr == A_HI);
  wire rd_lo    = rd_en && (addr == A_LO);
  wire div_full = &div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sec_q <= '0;
    end else if (load) begin
      div_q <= '0;
      sec_q <= {wdata, stage_q};
    end else if (tick) begin
      div_q <= div_q + 1'b1;
      if (div_full) sec_q <= sec_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      stage_q  <= '0;
      shadow_q <= '0;
      tick_irq <= 1'b0;
    end else begin
      tick_irq <= tick;
      if (wr_stat)  flag_q   <= wdata[BUS_W-1:DIV_W];
      if (wr_stage) stage_q  <= wdata;
      if (rd_lo)    shadow_q <= sec_q[SEC_W-1:BUS_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_STAT:  rdata <= {flag_q, div_q};
        A_LO:    rdata <= sec_q[BUS_W-1:0];
        A_HI:    rdata <= shadow_q;
        default: rdata <= '0;
      endcase
    end
  end

  // R2
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !div_full) |=> (div_q == $past(div_q) + 1'b1) && $stable(sec_q));
  // R3, R9
  a_r3_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && div_full) |=> (div_q == '0) && (sec_q == SEC_W'($past(sec_q) + 1'b1)));
  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> $stable(flag_q));
  a_r7_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> tick_irq);
  a_r7_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !tick_irq);
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (div_q == '0) && (sec_q[SEC_W-1:BUS_W] == $past(wdata)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/rt_seconds_bench.sv
`timescale 1ns/1ps
module rt_seconds_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic tick_irq;

  int checks = 0;
  int failures = 0;

  int m_div = 0, m_flags = 0, m_stage = 0, m_shadow = 0, m_rd = 0, m_irq = 0;
  longint m_sec = 0;

  always #4 clk = ~clk;

  rt_seconds u_rt_seconds (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tick_irq(tick_irq)
  );

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input bit t, input bit rd, input bit wr, input int a,
                     input int d, input string tag);
    tick = t; rd_en = rd; wr_en = wr; addr = a[1:0]; wdata = d[15:0];
    @(posedge clk);
    m_irq = t;
    if (rd) begin
      case (a)
        0: m_rd = (m_flags << 6) | m_div;
        1: begin m_rd = int'(m_sec & 64'hFFFF); m_shadow = int'((m_sec >> 16) & 64'hFFFF); end
        2: m_rd = m_shadow;
        default: m_rd = 0;
      endcase
    end
    if (wr && a == 0) m_flags = (d >> 6) & 10'h3FF;
    if (wr && a == 1) m_stage = d & 16'hFFFF;
    if (wr && a == 2) begin
      m_sec = (longint'(d & 16'hFFFF) << 16) | longint'(m_stage);
      m_div = 0;
    end else if (t) begin
      if (m_div == 63) begin
        m_div = 0;
        m_sec = (m_sec + 1) & 64'hFFFF_FFFF;
      end else m_div++;
    end
    @(negedge clk);
    chk({tag, " rdata"}, rdata, m_rd);
    chk({tag, " tick_irq"}, tick_irq, m_irq);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, tag);
  endtask

  task automatic rd(input int a, input string tag, input longint exp);
    cyc(0, 1, 0, a, 0, tag);
    chk(tag, rdata, exp);
  endtask

  task automatic load32(input longint v);
    cyc(0, 0, 1, 1, int'(v & 64'hFFFF), "R8");
    cyc(0, 0, 1, 2, int'((v >> 16) & 64'hFFFF), "R8");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 0);
    chk("R1 tick_irq", tick_irq, 0);
    rst_n = 1'b1;
    idle("R1");
    rd(0, "R1 status", 0);
    rd(1, "R1 low", 0);
    rd(2, "R1 high", 0);

    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, "R2 R7");
    chk("R7 pulse", tick_irq, 1);
    idle("R7");
    chk("R7 low", tick_irq, 0);
    rd(0, "R2 status", 5);
    rd(1, "R2 seconds", 0);

    cyc(1, 0, 1, 0, 16'hABFF, "R4");
    rd(0, "R4 status", 16'hABC6);

    for (int i = 0; i < 57; i++) cyc(1, 0, 0, 0, 0, "R2");
    rd(0, "R2 at top", 16'hABFF);
    rd(1, "R2 no carry", 0);
    cyc(1, 0, 0, 0, 0, "R3");
    rd(0, "R3 wrapped prescaler", 16'hABC0);
    rd(1, "R3 seconds", 1);

    rd(2, "R5 hold", 0);
    idle("R5");
    chk("R5 hold idle", rdata, 0);
    rd(3, "R10 unused", 0);

    load32(64'h0000_FFFF);
    rd(1, "R8 low", 16'hFFFF);
    rd(2, "R8 high", 0);
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, 0, "R2");
    cyc(0, 0, 1, 1, 16'h1234, "R8");
    cyc(1, 0, 1, 2, 16'h0000, "R8 vs tick");
    rd(0, "R8 prescaler cleared", 16'hABC0);
    rd(1, "R8 low", 16'h1234);

    load32(64'h0000_FFFF);
    for (int i = 0; i < 63; i++) cyc(1, 0, 0, 0, 0, "R2");
    cyc(1, 1, 0, 1, 0, "R6");
    chk("R6 low before carry", rdata, 16'hFFFF);
    rd(2, "R6 coherent high", 0);
    rd(1, "R3 low after carry", 0);
    rd(2, "R3 high after carry", 1);

    load32(64'hFFFF_FFFF);
    for (int i = 0; i < 64; i++) cyc(1, 0, 0, 0, 0, "R9");
    rd(1, "R9 low", 0);
    rd(2, "R9 high", 0);
    rd(0, "R4 flags kept", 16'hABC0);

    idle("R7");
    finish_run();
  end
endmodule